// File: doc/BRIEF.md
# Load Store-Forwarding Lookup Unit

When a load executes, this block decides where its data comes from. It takes the store-queue position captured for the load at dispatch and searches the stores older than that load, youngest first, back to and including the store at the writeback boundary. For each store it compares the store's byte range with the load's byte range.

If a store covers every byte the load needs, the block returns the forwarded bytes one cycle later and does not use a cache port. If a store holds only some of the load's bytes and has not completed, the load is sent back for replay. The block also records, oldest load first, which store is holding the queue up. When nothing matches, the load is issued to the data cache. A blocked cache marks the load as blocked instead. An uncacheable load is refused with a fault unless it sits at the load-queue head and has reached commit.

The store queue is presented as flattened input arrays, and the cache as a request output with a blocked input and a hit/miss response. Every result is a single-cycle pulse in the cycle after the load is presented.

Top module: `ldfwd_lookup`

## Requirements
- R1: The stores examined are the slots `ld_sq_idx-1`, `ld_sq_idx-2`, and so on, wrapping from slot 0 to slot SQ_N-1, down to and including `sq_wb_idx`. When `ld_sq_idx == sq_wb_idx`, no store is examined.
- R2: A store slot whose size field is 0 is skipped as if absent.
- R3: If a store satisfies `st_addr <= ld_addr` and `ld_addr+ld_size <= st_addr+st_size`, then in the next cycle `fwd_valid` is 1 for exactly one cycle. `fwd_data` carries the store data shifted right by `(ld_addr & (st_size-1))*8`, keeping only the low `ld_size` bytes; its other bytes are zero.
- R4: A store that overlaps the load only partly and whose completed bit is 1 is skipped, and the search continues with the next older slot.
- R5: A partial overlap with a store whose completed bit is 0 gives `replay_valid` for one cycle, with no forward and no cache request.
- R6: On that partial-overlap outcome, the stall record (`stalled`, `stall_st_seq`, `stall_lq_idx`) is loaded if no stall is held or if the load's sequence number is smaller than that of the recorded load. Otherwise the record is unchanged.
- R7: `stall_release` clears `stalled` at the next edge. A partial-overlap outcome in the same cycle loads a fresh record.
- R8: With no matching store, a load makes `ports_used` equal 1 in the next cycle. `ports_used` is 0 in every cycle that follows no cache-bound load, including forwards.
- R9: A cache-bound load with `cache_blocked` at 1 issues no request. It loads `ld_blocked`/`blocked_seq` unless the recorded blocked load has a smaller sequence number. `block_release` clears `ld_blocked`.
- R10: An uncacheable load whose `ld_lq_idx` differs from `lq_head`, or whose `ld_at_commit` is 0, gives `fault_valid` and `replay_valid` and skips the search. Otherwise it is handled like any other load.
- R11: A cache response with hit at 0 sets `miss_stall`, and a response with hit at 1 clears it.
- R12: Among several matching stores, the first one met in search order (the youngest older store) decides the outcome.
- R13: After reset all pulses are 0, and `stalled`, `ld_blocked` and `miss_stall` are 0 with their recorded fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load executes this cycle |
| ld_lq_idx | input | LQ_IW | Load-queue slot of the load |
| ld_sq_idx | input | SQ_IW | Store-queue position captured at dispatch |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SZ_W | Load size in bytes (1, 2, 4, 8) |
| ld_seq | input | SEQ_W | Load age; smaller is older |
| ld_uncached | input | 1 | Load targets uncacheable space |
| ld_at_commit | input | 1 | Load has reached commit |
| lq_head | input | LQ_IW | Current load-queue head slot |
| sq_wb_idx | input | SQ_IW | Store writeback boundary slot |
| sq_addr_flat | input | SQ_N*ADDR_W | Store addresses, slot i at bits i*ADDR_W |
| sq_size_flat | input | SQ_N*SZ_W | Store sizes, 0 = unknown |
| sq_data_flat | input | SQ_N*DATA_W | Store data |
| sq_done_flat | input | SQ_N | Store completed bits |
| sq_seq_flat | input | SQ_N*SEQ_W | Store sequence numbers |
| cache_blocked | input | 1 | Cache cannot accept a request |
| cache_resp_valid | input | 1 | Cache response present |
| cache_resp_hit | input | 1 | Response was a hit |
| stall_release | input | 1 | Stalling store has written back |
| block_release | input | 1 | Blocked-load condition handled |
| fwd_valid | output | 1 | Forwarded data pulse |
| fwd_data | output | DATA_W | Forwarded data |
| res_lq_idx | output | LQ_IW | Load slot of this cycle's result |
| replay_valid | output | 1 | Load must be replayed |
| fault_valid | output | 1 | Uncacheable load refused |
| cache_req_valid | output | 1 | Cache read request |
| cache_req_addr | output | ADDR_W | Cache request address |
| ports_used | output | PORT_W | Cache ports used by the previous cycle's load |
| stalled | output | 1 | Partial-overlap stall held |
| stall_st_seq | output | SEQ_W | Sequence number of the stalling store |
| stall_lq_idx | output | LQ_IW | Load slot of the oldest stalled load |
| ld_blocked | output | 1 | A load met a blocked cache |
| blocked_seq | output | SEQ_W | Sequence number of the oldest blocked load |
| miss_stall | output | 1 | Last cache response was a miss |

## Verification
The bench builds the block with eight store slots, an eight-entry load queue, 16-bit addresses and 64-bit data. Eight slots are few enough that the search window can be placed across the wrap from slot 0 to slot 7, made empty by setting start equal to the boundary, and narrowed to a single slot. Byte offsets within an 8-byte store reach the largest shift, 56 bits. Sequence numbers of 8 bits leave room for older and younger loads to take over, or fail to take over, the stall and blocked records.

// File: rtl/ldfwd_pkg.sv
package ldfwd_pkg;

  // Outcome of one load lookup.
  typedef enum logic [2:0] {
    K_IDLE   = 3'd0,
    K_FWD    = 3'd1,
    K_REPLAY = 3'd2,
    K_MEM    = 3'd3,
    K_FAULT  = 3'd4
  } lfu_kind_e;

endpackage

// File: rtl/ldfwd_cmp.sv
// Byte-range comparison of one store slot against the load.
module ldfwd_cmp #(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 4
) (
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SZ_W-1:0]   ld_size,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SZ_W-1:0]   st_size,
  input  logic              st_done,
  output logic              covers,
  output logic              live_part
);
  localparam int AW1 = ADDR_W + 1;

  function automatic logic [AW1-1:0] span_end(input logic [ADDR_W-1:0] a,
                                               input logic [SZ_W-1:0] s);
    return {1'b0, a} + AW1'(s);
  endfunction

  logic known, touch;
  logic [AW1-1:0] ld_end, st_end;

  always_comb begin
    ld_end    = span_end(ld_addr, ld_size);
    st_end    = span_end(st_addr, st_size);
    known     = (st_size != '0);
    covers    = known && (ld_addr >= st_addr) && (ld_end <= st_end);
    touch     = known && ({1'b0, ld_addr} < st_end) && (ld_end > {1'b0, st_addr});
    live_part = touch && !covers && !st_done;
  end
endmodule

// File: rtl/ldfwd_scan.sv
// Parallel search of the store window, youngest older store first.
module ldfwd_scan #(
  parameter int SQ_N   = 8,
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 4,
  parameter int DATA_W = 64,
  parameter int SEQ_W  = 8,
  localparam int SQ_IW = (SQ_N > 1) ? $clog2(SQ_N) : 1,
  localparam int SH_W  = SZ_W + 3
) (
  input  logic [SQ_IW-1:0]       start_idx,
  input  logic [SQ_IW-1:0]       wb_idx,
  input  logic [ADDR_W-1:0]      ld_addr,
  input  logic [SZ_W-1:0]        ld_size,
  input  logic [SQ_N*ADDR_W-1:0] sq_addr_flat,
  input  logic [SQ_N*SZ_W-1:0]   sq_size_flat,
  input  logic [SQ_N*DATA_W-1:0] sq_data_flat,
  input  logic [SQ_N-1:0]        sq_done_flat,
  input  logic [SQ_N*SEQ_W-1:0]  sq_seq_flat,
  output logic                   hit,
  output logic                   hit_full,
  output logic [SQ_IW-1:0]       hit_idx,
  output logic [SEQ_W-1:0]       hit_seq,
  output logic [DATA_W-1:0]      hit_data
);
  localparam int NBYTES = DATA_W / 8;

  // Slot reached after stepping k+1 entries older than the start.
  function automatic logic [SQ_IW-1:0] back_idx(input logic [SQ_IW-1:0] s, input int k);
    int t;
    t = int'(s) - 1 - k;
    if (t < 0) t = t + SQ_N;
    return SQ_IW'(t);
  endfunction

  // Number of slots between start and the writeback boundary, inclusive of the boundary.
  function automatic int window_len(input logic [SQ_IW-1:0] s, input logic [SQ_IW-1:0] w);
    int d;
    d = int'(s) - int'(w);
    if (d < 0) d = d + SQ_N;
    return d;
  endfunction

  function automatic logic [SH_W-1:0] shift_bits(input logic [ADDR_W-1:0] la,
                                                 input logic [SZ_W-1:0] ss);
    logic [SZ_W-1:0] off;
    off = la[SZ_W-1:0] & (ss - SZ_W'(1));
    return {off, 3'b000};
  endfunction

  function automatic logic [DATA_W-1:0] keep_bytes(input logic [SZ_W-1:0] ls);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < NBYTES; b++)
      if (b < int'(ls)) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  logic [SQ_IW-1:0] slot [SQ_N];
  logic [SQ_N-1:0]  cand_full, cand_part;
  int               win;

  assign win = window_len(start_idx, wb_idx);

  for (genvar k = 0; k < SQ_N; k++) begin : g_slot
    logic c_full, c_part;
    assign slot[k] = back_idx(start_idx, k);
    ldfwd_cmp #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_cmp (
      .ld_addr  (ld_addr),
      .ld_size  (ld_size),
      .st_addr  (sq_addr_flat[int'(slot[k])*ADDR_W +: ADDR_W]),
      .st_size  (sq_size_flat[int'(slot[k])*SZ_W +: SZ_W]),
      .st_done  (sq_done_flat[slot[k]]),
      .covers   (c_full),
      .live_part(c_part)
    );
    assign cand_full[k] = (k < win) && c_full;
    assign cand_part[k] = (k < win) && c_part;
  end

  logic [SZ_W-1:0]   sel_size;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    hit      = 1'b0;
    hit_full = 1'b0;
    hit_idx  = '0;
    for (int k = 0; k < SQ_N; k++) begin
      if (!hit && (cand_full[k] || cand_part[k])) begin
        hit      = 1'b1;
        hit_full = cand_full[k];
        hit_idx  = slot[k];
      end
    end
    sel_size = sq_size_flat[int'(hit_idx)*SZ_W +: SZ_W];
    sel_data = sq_data_flat[int'(hit_idx)*DATA_W +: DATA_W];
    hit_seq  = sq_seq_flat[int'(hit_idx)*SEQ_W +: SEQ_W];
    hit_data = (sel_data >> shift_bits(ld_addr, sel_size)) & keep_bytes(ld_size);
  end
endmodule

// File: rtl/ldfwd_track.sv
// Oldest-first stall record, blocked-load record and miss status.
module ldfwd_track #(
  parameter int LQ_IW = 3,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             part_go,
  input  logic             blk_go,
  input  logic [SEQ_W-1:0] ld_seq,
  input  logic [LQ_IW-1:0] ld_lq_idx,
  input  logic [SEQ_W-1:0] st_seq,
  input  logic             stall_release,
  input  logic             block_release,
  input  logic             resp_valid,
  input  logic             resp_hit,
  output logic             stalled,
  output logic [SEQ_W-1:0] stall_st_seq,
  output logic [LQ_IW-1:0] stall_lq_idx,
  output logic             ld_blocked,
  output logic [SEQ_W-1:0] blocked_seq,
  output logic             miss_stall
);
  logic [SEQ_W-1:0] stall_ld_seq;
  logic             stall_keep, blk_keep, take_stall, take_blk;

  always_comb begin
    stall_keep = stalled && !stall_release;
    blk_keep   = ld_blocked && !block_release;
    take_stall = part_go && (!stall_keep || (ld_seq < stall_ld_seq));
    take_blk   = blk_go && (!blk_keep || !(blocked_seq < ld_seq));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stalled      <= 1'b0;
      stall_st_seq <= '0;
      stall_lq_idx <= '0;
      stall_ld_seq <= '0;
      ld_blocked   <= 1'b0;
      blocked_seq  <= '0;
      miss_stall   <= 1'b0;
    end else begin
      if (take_stall) begin
        stalled      <= 1'b1;
        stall_st_seq <= st_seq;
        stall_lq_idx <= ld_lq_idx;
        stall_ld_seq <= ld_seq;
      end else begin
        stalled <= stall_keep;
      end
      if (take_blk) begin
        ld_blocked  <= 1'b1;
        blocked_seq <= ld_seq;
      end else begin
        ld_blocked <= blk_keep;
      end
      if (resp_valid) miss_stall <= !resp_hit;
    end
  end
endmodule

// File: rtl/ldfwd_lookup.sv
module ldfwd_lookup #(
  parameter int SQ_N   = 8,
  parameter int LQ_N   = 8,
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 4,
  parameter int DATA_W = 64,
  parameter int SEQ_W  = 8,
  parameter int PORT_W = 2,
  localparam int SQ_IW = (SQ_N > 1) ? $clog2(SQ_N) : 1,
  localparam int LQ_IW = (LQ_N > 1) ? $clog2(LQ_N) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic [LQ_IW-1:0]       ld_lq_idx,
  input  logic [SQ_IW-1:0]       ld_sq_idx,
  input  logic [ADDR_W-1:0]      ld_addr,
  input  logic [SZ_W-1:0]        ld_size,
  input  logic [SEQ_W-1:0]       ld_seq,
  input  logic                   ld_uncached,
  input  logic                   ld_at_commit,
  input  logic [LQ_IW-1:0]       lq_head,
  input  logic [SQ_IW-1:0]       sq_wb_idx,
  input  logic [SQ_N*ADDR_W-1:0] sq_addr_flat,
  input  logic [SQ_N*SZ_W-1:0]   sq_size_flat,
  input  logic [SQ_N*DATA_W-1:0] sq_data_flat,
  input  logic [SQ_N-1:0]        sq_done_flat,
  input  logic [SQ_N*SEQ_W-1:0]  sq_seq_flat,
  input  logic                   cache_blocked,
  input  logic                   cache_resp_valid,
  input  logic                   cache_resp_hit,
  input  logic                   stall_release,
  input  logic                   block_release,
  output logic                   fwd_valid,
  output logic [DATA_W-1:0]      fwd_data,
  output logic [LQ_IW-1:0]       res_lq_idx,
  output logic                   replay_valid,
  output logic                   fault_valid,
  output logic                   cache_req_valid,
  output logic [ADDR_W-1:0]      cache_req_addr,
  output logic [PORT_W-1:0]      ports_used,
  output logic                   stalled,
  output logic [SEQ_W-1:0]       stall_st_seq,
  output logic [LQ_IW-1:0]       stall_lq_idx,
  output logic                   ld_blocked,
  output logic [SEQ_W-1:0]       blocked_seq,
  output logic                   miss_stall
);
  import ldfwd_pkg::*;

  logic              hit, hit_full;
  logic [SQ_IW-1:0]  hit_idx;
  logic [SEQ_W-1:0]  hit_seq;
  logic [DATA_W-1:0] hit_data;

  ldfwd_scan #(
    .SQ_N(SQ_N), .ADDR_W(ADDR_W), .SZ_W(SZ_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)
  ) u_scan (
    .start_idx   (ld_sq_idx),
    .wb_idx      (sq_wb_idx),
    .ld_addr     (ld_addr),
    .ld_size     (ld_size),
    .sq_addr_flat(sq_addr_flat),
    .sq_size_flat(sq_size_flat),
    .sq_data_flat(sq_data_flat),
    .sq_done_flat(sq_done_flat),
    .sq_seq_flat (sq_seq_flat),
    .hit         (hit),
    .hit_full    (hit_full),
    .hit_idx     (hit_idx),
    .hit_seq     (hit_seq),
    .hit_data    (hit_data)
  );

  // Named lookup events, observed by the bound checker.
  lfu_kind_e kind;
  logic      uc_refuse, ev_fwd, ev_part, ev_fault, ev_mem, ev_cache, ev_blk;

  always_comb begin
    uc_refuse = ld_uncached && ((ld_lq_idx != lq_head) || !ld_at_commit);
    if (!ld_valid)      kind = K_IDLE;
    else if (uc_refuse) kind = K_FAULT;
    else if (!hit)      kind = K_MEM;
    else if (hit_full)  kind = K_FWD;
    else                kind = K_REPLAY;
    ev_fwd   = (kind == K_FWD);
    ev_part  = (kind == K_REPLAY);
    ev_fault = (kind == K_FAULT);
    ev_mem   = (kind == K_MEM);
    ev_cache = ev_mem && !cache_blocked;
    ev_blk   = ev_mem && cache_blocked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid       <= 1'b0;
      fwd_data        <= '0;
      res_lq_idx      <= '0;
      replay_valid    <= 1'b0;
      fault_valid     <= 1'b0;
      cache_req_valid <= 1'b0;
      cache_req_addr  <= '0;
      ports_used      <= '0;
    end else begin
      fwd_valid       <= ev_fwd;
      fwd_data        <= ev_fwd ? hit_data : '0;
      res_lq_idx      <= ld_valid ? ld_lq_idx : '0;
      replay_valid    <= ev_part || ev_fault;
      fault_valid     <= ev_fault;
      cache_req_valid <= ev_cache;
      cache_req_addr  <= ev_cache ? ld_addr : '0;
      ports_used      <= ev_mem ? PORT_W'(1) : '0;
    end
  end

  ldfwd_track #(.LQ_IW(LQ_IW), .SEQ_W(SEQ_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .part_go      (ev_part),
    .blk_go       (ev_blk),
    .ld_seq       (ld_seq),
    .ld_lq_idx    (ld_lq_idx),
    .st_seq       (hit_seq),
    .stall_release(stall_release),
    .block_release(block_release),
    .resp_valid   (cache_resp_valid),
    .resp_hit     (cache_resp_hit),
    .stalled      (stalled),
    .stall_st_seq (stall_st_seq),
    .stall_lq_idx (stall_lq_idx),
    .ld_blocked   (ld_blocked),
    .blocked_seq  (blocked_seq),
    .miss_stall   (miss_stall)
  );
endmodule

// File: rtl/ldfwd_lookup_chk.sv
module ldfwd_lookup_chk #(
  parameter int PORT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_uncached,
  input logic              cache_blocked,
  input logic              cache_resp_valid,
  input logic              cache_resp_hit,
  input logic              stall_release,
  input logic              block_release,
  input logic              ev_part,
  input logic              fwd_valid,
  input logic              replay_valid,
  input logic              fault_valid,
  input logic              cache_req_valid,
  input logic [PORT_W-1:0] ports_used,
  input logic              stalled,
  input logic              ld_blocked,
  input logic              miss_stall
);
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, replay_valid, cache_req_valid}));

  a_r3_fwd_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(ld_valid));

  a_r5_partial_replays: assert property (@(posedge clk) disable iff (!rst_n)
    ev_part |=> (replay_valid && !fwd_valid && !cache_req_valid));

  a_r10_fault_replays: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (replay_valid && $past(ld_uncached)));

  a_r8_port_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    cache_req_valid |-> (ports_used == PORT_W'(1)));

  a_r9_no_req_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    cache_req_valid |-> !$past(cache_blocked));

  a_r9_block_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_blocked) |-> $past(block_release));

  a_r7_stall_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stalled) |-> $past(stall_release));

  a_r11_miss_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_stall) |-> $past(cache_resp_valid && !cache_resp_hit));
endmodule

bind ldfwd_lookup ldfwd_lookup_chk #(.PORT_W(PORT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ld_valid        (ld_valid),
  .ld_uncached     (ld_uncached),
  .cache_blocked   (cache_blocked),
  .cache_resp_valid(cache_resp_valid),
  .cache_resp_hit  (cache_resp_hit),
  .stall_release   (stall_release),
  .block_release   (block_release),
  .ev_part         (ev_part),
  .fwd_valid       (fwd_valid),
  .replay_valid    (replay_valid),
  .fault_valid     (fault_valid),
  .cache_req_valid (cache_req_valid),
  .ports_used      (ports_used),
  .stalled         (stalled),
  .ld_blocked      (ld_blocked),
  .miss_stall      (miss_stall)
);

// File: tb/ldfwd_lookup_bench.sv
module ldfwd_lookup_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ld_valid, ld_uncached, ld_at_commit;
  logic [2:0]  ld_lq_idx, ld_sq_idx, lq_head, sq_wb_idx;
  logic [15:0] ld_addr;
  logic [3:0]  ld_size;
  logic [7:0]  ld_seq;
  logic        cache_blocked, cache_resp_valid, cache_resp_hit, stall_release, block_release;

  logic [15:0] s_addr [N];
  logic [3:0]  s_size [N];
  logic [63:0] s_data [N];
  logic        s_done [N];
  logic [7:0]  s_seq  [N];

  logic [N*16-1:0] f_addr;
  logic [N*4-1:0]  f_size;
  logic [N*64-1:0] f_data;
  logic [N-1:0]    f_done;
  logic [N*8-1:0]  f_seq;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      f_addr[i*16 +: 16] = s_addr[i];
      f_size[i*4 +: 4]   = s_size[i];
      f_data[i*64 +: 64] = s_data[i];
      f_done[i]          = s_done[i];
      f_seq[i*8 +: 8]    = s_seq[i];
    end
  end

  logic        fwd_valid, replay_valid, fault_valid, cache_req_valid, stalled, ld_blocked, miss_stall;
  logic [63:0] fwd_data;
  logic [2:0]  res_lq_idx, stall_lq_idx;
  logic [15:0] cache_req_addr;
  logic [1:0]  ports_used;
  logic [7:0]  stall_st_seq, blocked_seq;

  ldfwd_lookup u_ldfwd_lookup (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_lq_idx(ld_lq_idx), .ld_sq_idx(ld_sq_idx),
    .ld_addr(ld_addr), .ld_size(ld_size), .ld_seq(ld_seq), .ld_uncached(ld_uncached),
    .ld_at_commit(ld_at_commit), .lq_head(lq_head), .sq_wb_idx(sq_wb_idx),
    .sq_addr_flat(f_addr), .sq_size_flat(f_size), .sq_data_flat(f_data), .sq_done_flat(f_done),
    .sq_seq_flat(f_seq), .cache_blocked(cache_blocked), .cache_resp_valid(cache_resp_valid),
    .cache_resp_hit(cache_resp_hit), .stall_release(stall_release), .block_release(block_release),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .res_lq_idx(res_lq_idx), .replay_valid(replay_valid),
    .fault_valid(fault_valid), .cache_req_valid(cache_req_valid), .cache_req_addr(cache_req_addr),
    .ports_used(ports_used), .stalled(stalled), .stall_st_seq(stall_st_seq),
    .stall_lq_idx(stall_lq_idx), .ld_blocked(ld_blocked), .blocked_seq(blocked_seq),
    .miss_stall(miss_stall)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference model state
  bit       m_st = 0, m_blk = 0, m_miss = 0;
  bit [7:0] m_st_seq = 0, m_ld_seq = 0, m_blk_seq = 0;
  bit [2:0] m_st_lq = 0;

  // Expected outputs for the cycle after the current stimulus
  bit        e_fwd, e_rep, e_fault, e_creq;
  bit [63:0] e_data;
  bit [15:0] e_caddr;
  bit [1:0]  e_ports;
  bit [2:0]  e_idx;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "fwd_valid", 64'(fwd_valid), 64'(e_fwd));
    chk(tag, "fwd_data", fwd_data, e_data);
    chk(tag, "replay_valid", 64'(replay_valid), 64'(e_rep));
    chk(tag, "fault_valid", 64'(fault_valid), 64'(e_fault));
    chk(tag, "cache_req_valid", 64'(cache_req_valid), 64'(e_creq));
    chk(tag, "cache_req_addr", 64'(cache_req_addr), 64'(e_caddr));
    chk(tag, "ports_used", 64'(ports_used), 64'(e_ports));
    chk(tag, "res_lq_idx", 64'(res_lq_idx), 64'(e_idx));
    chk(tag, "stalled", 64'(stalled), 64'(m_st));
    chk(tag, "stall_st_seq", 64'(stall_st_seq), 64'(m_st_seq));
    chk(tag, "stall_lq_idx", 64'(stall_lq_idx), 64'(m_st_lq));
    chk(tag, "ld_blocked", 64'(ld_blocked), 64'(m_blk));
    chk(tag, "blocked_seq", 64'(blocked_seq), 64'(m_blk_seq));
    chk(tag, "miss_stall", 64'(miss_stall), 64'(m_miss));
  endtask

  // Apply current inputs for one clock, predicting the outcome behaviourally.
  task automatic cyc(input string tag);
    int        kind;   // 0 idle, 1 fwd, 2 replay, 3 memory, 4 fault
    int        idx, la, ls, sa, ss;
    bit [63:0] d;
    bit [7:0]  hseq;
    bit        base;
    kind = 0; d = 0; hseq = 0;
    if (ld_valid) begin
      if (ld_uncached && (ld_lq_idx != lq_head || !ld_at_commit)) kind = 4;
      else begin
        kind = 3;
        idx  = int'(ld_sq_idx);
        while (idx != int'(sq_wb_idx)) begin
          idx = idx - 1;
          if (idx < 0) idx = N - 1;
          if (s_size[idx] == 0) continue;
          la = int'(ld_addr); ls = int'(ld_size); sa = int'(s_addr[idx]); ss = int'(s_size[idx]);
          if (la >= sa && la + ls <= sa + ss) begin
            kind = 1;
            d = s_data[idx] >> ((la & (ss - 1)) * 8);
            if (ls < 8) d = d & ((64'd1 << (8 * ls)) - 64'd1);
            break;
          end
          if (la < sa + ss && la + ls > sa && !s_done[idx]) begin
            kind = 2; hseq = s_seq[idx];
            break;
          end
        end
      end
    end
    e_fwd   = (kind == 1);
    e_data  = (kind == 1) ? d : 64'd0;
    e_rep   = (kind == 2) || (kind == 4);
    e_fault = (kind == 4);
    e_creq  = (kind == 3) && !cache_blocked;
    e_caddr = e_creq ? ld_addr : 16'd0;
    e_ports = (kind == 3) ? 2'd1 : 2'd0;
    e_idx   = ld_valid ? ld_lq_idx : 3'd0;
    base = m_st && !stall_release;
    if (kind == 2 && (!base || ld_seq < m_ld_seq)) begin
      m_st = 1; m_st_seq = hseq; m_st_lq = ld_lq_idx; m_ld_seq = ld_seq;
    end else m_st = base;
    base = m_blk && !block_release;
    if (kind == 3 && cache_blocked && (!base || !(m_blk_seq < ld_seq))) begin
      m_blk = 1; m_blk_seq = ld_seq;
    end else m_blk = base;
    if (cache_resp_valid) m_miss = !cache_resp_hit;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle();
    ld_valid = 0; ld_uncached = 0; ld_at_commit = 0;
    stall_release = 0; block_release = 0; cache_resp_valid = 0; cache_resp_hit = 0;
  endtask

  task automatic load(input logic [15:0] a, input logic [3:0] sz, input logic [7:0] sq,
                      input logic [2:0] lq, input logic [2:0] start);
    idle();
    ld_valid = 1; ld_addr = a; ld_size = sz; ld_seq = sq; ld_lq_idx = lq; ld_sq_idx = start;
  endtask

  task automatic clear_sq();
    for (int i = 0; i < N; i++) begin
      s_addr[i] = 0; s_size[i] = 0; s_data[i] = 0; s_done[i] = 0; s_seq[i] = 0;
    end
  endtask

  task automatic put(input int i, input logic [15:0] a, input logic [3:0] sz,
                     input logic [63:0] dt, input logic dn, input logic [7:0] sq);
    s_addr[i] = a; s_size[i] = sz; s_data[i] = dt; s_done[i] = dn; s_seq[i] = sq;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clear_sq(); idle();
    ld_addr = 0; ld_size = 0; ld_seq = 0; ld_lq_idx = 0; ld_sq_idx = 0;
    lq_head = 0; sq_wb_idx = 0; cache_blocked = 0;
    repeat (3) @(negedge clk);
    e_fwd = 0; e_data = 0; e_rep = 0; e_fault = 0; e_creq = 0; e_caddr = 0; e_ports = 0; e_idx = 0;
    compare_all("R13");
    rst_n = 1;
    idle(); cyc("R13");

    // R3: full containment and shifted, masked data; window slots 2,1,0
    put(2, 16'h0100, 4'd8, 64'h1122334455667788, 0, 8'h20);
    load(16'h0100, 4'd4, 8'd10, 3'd1, 3'd3); cyc("R3");
    load(16'h0104, 4'd4, 8'd11, 3'd2, 3'd3); cyc("R3");
    load(16'h0106, 4'd2, 8'd12, 3'd3, 3'd3); cyc("R3");
    load(16'h0107, 4'd1, 8'd13, 3'd4, 3'd3); cyc("R3");
    idle(); cyc("R3");
    idle(); cyc("R8");

    // R12: youngest older store wins; R2: size-zero slot skipped
    put(1, 16'h0100, 4'd8, 64'hA1A2A3A4A5A6A7A8, 0, 8'h18);
    load(16'h0100, 4'd4, 8'd14, 3'd1, 3'd3); cyc("R12");
    s_size[2] = 0;
    load(16'h0100, 4'd4, 8'd15, 3'd1, 3'd3); cyc("R2");

    // R1: window narrowed to slot 2 only, which is empty -> cache
    sq_wb_idx = 3'd2;
    load(16'h0100, 4'd4, 8'd16, 3'd5, 3'd3); cyc("R1");
    idle(); cyc("R8");
    // R1: wrap 0 -> 7 with boundary 6
    clear_sq();
    put(7, 16'h0200, 4'd8, 64'h0F0E0D0C0B0A0908, 0, 8'h07);
    sq_wb_idx = 3'd6;
    load(16'h0204, 4'd4, 8'd17, 3'd6, 3'd1); cyc("R1");
    // R1: boundary at slot 7 still included
    sq_wb_idx = 3'd7;
    load(16'h0200, 4'd2, 8'd18, 3'd6, 3'd1); cyc("R1");
    // R1: empty window
    sq_wb_idx = 3'd1;
    load(16'h0200, 4'd2, 8'd19, 3'd6, 3'd1); cyc("R1");

    // R5/R6: partial overlap with live store
    sq_wb_idx = 3'd0; clear_sq();
    put(2, 16'h0102, 4'd4, 64'h00000000DEADBEEF, 0, 8'h22);
    load(16'h0100, 4'd4, 8'd30, 3'd3, 3'd3); cyc("R5");
    load(16'h0100, 4'd4, 8'd40, 3'd4, 3'd3); cyc("R6");
    load(16'h0100, 4'd4, 8'd25, 3'd5, 3'd3); cyc("R6");
    idle(); stall_release = 1; cyc("R7");
    load(16'h0100, 4'd4, 8'd60, 3'd2, 3'd3); cyc("R6");
    load(16'h0100, 4'd4, 8'd70, 3'd6, 3'd3); stall_release = 1; cyc("R7");
    idle(); stall_release = 1; cyc("R7");

    // R4: partial overlap with completed store is skipped
    s_done[2] = 1;
    load(16'h0100, 4'd4, 8'd31, 3'd1, 3'd3); cyc("R4");
    put(1, 16'h00F8, 4'd8, 64'h8877665544332211, 0, 8'h11);
    load(16'h00FC, 4'd4, 8'd32, 3'd1, 3'd3); cyc("R4");

    // R9: blocked cache, oldest-first record, release
    clear_sq(); cache_blocked = 1;
    load(16'h0300, 4'd8, 8'd50, 3'd2, 3'd3); cyc("R9");
    load(16'h0308, 4'd8, 8'd60, 3'd3, 3'd3); cyc("R9");
    load(16'h0310, 4'd8, 8'd45, 3'd4, 3'd3); cyc("R9");
    idle(); block_release = 1; cyc("R9");
    cache_blocked = 0;
    load(16'h0318, 4'd8, 8'd46, 3'd4, 3'd3); cyc("R8");

    // R10: uncacheable loads
    put(2, 16'h0400, 4'd8, 64'hCAFEF00D12345678, 0, 8'h44);
    lq_head = 3'd0;
    load(16'h0400, 4'd4, 8'd80, 3'd3, 3'd3); ld_uncached = 1; ld_at_commit = 1; cyc("R10");
    load(16'h0400, 4'd4, 8'd81, 3'd0, 3'd3); ld_uncached = 1; ld_at_commit = 0; cyc("R10");
    load(16'h0400, 4'd4, 8'd82, 3'd0, 3'd3); ld_uncached = 1; ld_at_commit = 1; cyc("R10");

    // R11: miss status
    idle(); cache_resp_valid = 1; cache_resp_hit = 0; cyc("R11");
    idle(); cyc("R11");
    idle(); cache_resp_valid = 1; cache_resp_hit = 1; cyc("R11");
    idle(); cyc("R11");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule